// File: doc/BRIEF.md
# Read-Timed Write Synthesizer for a Read-Only Cartridge Bus

This block sits on a cartridge port where the processor can only issue reads and builds write cycles out of a timed pair of them. A read anywhere in the low page of the cartridge window captures the low address byte as a pending data value and arms a sequencer. The sequencer then counts the cycles in which the address on the bus changes. The access that arrives on the fifth such change is the write target, provided it falls inside a fixed window of bus cycles after arming.

A target at the control offset loads the pending byte into an 8-bit control register. Any other cartridge target makes the block drive the pending byte onto the data bus and pulse the external RAM write strobe during that same read cycle. This only happens while the control register's write-enable bit is set.

A read at the status offset returns the tape input level in bit 0, with all other bits zero. Bank mapping and the RAM array are outside this block.

Top module: `snoop_write_ctl`

## Requirements
- R1: While rst_n is low and after it is released, ctrl_reg is 0x00, data_oe and ram_we are 0, and the sequencer is disarmed.
- R2: A valid access with addr == 0x1FF9 gives data_oe = 1, data_out = {7'b0, tape_in} and ram_we = 0 in the same cycle, whether or not the sequencer is armed.
- R3: A valid access with addr[12] = 1 and addr[11:8] = 0 latches addr[7:0] as the pending byte and arms the sequencer with both of its counters at zero.
- R4: Once armed, a valid cycle counts as a transition only if its address differs from the address of the previous valid cycle. The access on the 5th transition (TRANS_COUNT) is the target, and it disarms the sequencer.
- R5: Valid cycles are numbered from 1 after the arming access. A target is committed only if its number lies in 4..6. When cycle 6 passes without a commit, the sequencer disarms, and later transitions store nothing.
- R6: A committed target with addr[11:0] = 0xFF8 loads the pending byte into ctrl_reg, visible from the next cycle, with data_oe = 0 and ram_we = 0.
- R7: A committed target at any other cartridge address except 0xFF9, while ctrl_reg[1] = 1, gives data_out = pending byte, data_oe = 1 and ram_we = 1 in that cycle. ram_addr always equals addr[11:0].
- R8: While ctrl_reg[1] = 0, RAM targets produce neither data_oe nor ram_we, and control loads still take effect.
- R9: A trigger-page access while armed re-latches the pending byte and restarts counting from zero. The earlier arming then produces no write.
- R10: An access with addr[12] = 0 never arms and is never written. If it is the target, it still counts as a transition and disarms the sequencer.
- R11: A cycle with bus_valid = 0 has data_oe = 0 and ram_we = 0, does not advance any count, and does not replace the previous address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | High for one clock per processor bus cycle |
| addr | input | 13 | Cartridge-port address; bit 12 selects the cartridge window |
| tape_in | input | 1 | Tape audio level |
| data_out | output | 8 | Byte driven onto the data bus |
| data_oe | output | 1 | Output enable for data_out |
| ram_we | output | 1 | External RAM write strobe |
| ram_addr | output | 12 | RAM address, the low 12 bits of addr |
| ctrl_reg | output | 8 | Control register contents |

## Verification
Status reads, RAM write strobes and driven data are combinational on the current bus cycle, so they are due in the very cycle that carries the triggering address. A control-register load only shows on ctrl_reg one clock after its target cycle. The driver applies each bus cycle 1 ns after a rising edge and queues the outputs expected in that cycle, with ctrl_reg as already updated by earlier loads. The monitor compares the outputs 3 ns after the same edge, while the inputs are still stable. Sequences with repeated addresses, late targets, re-arming and idle bus cycles place the fifth transition on cycles where a cycle counter would disagree, and the expected values are set from transition counts alone.

// File: rtl/snoop_write_pkg.sv
// Package: shared widths and decode offsets for the read-timed write block.
// Assumes a 13-bit cartridge-port address whose bit 12 selects the cartridge.
package snoop_write_pkg;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 8;
    localparam int OFS_W   = 12;
    localparam logic [OFS_W-1:0] CTRL_OFS = 12'hFF8;
    localparam logic [OFS_W-1:0] STAT_OFS = 12'hFF9;
    localparam logic [3:0]       TRIG_HI  = 4'h0;
endpackage

// File: rtl/snoop_addr_track.sv
// Module: remembers the address of the last valid bus cycle and flags a
// change. Assumes bus_valid marks exactly one clock per bus cycle; idle
// clocks neither compare nor update the stored address.
module snoop_addr_track
    import snoop_write_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_changed
);
    logic [ADDR_W-1:0] prev_q;
    logic              seen_q;

    // Keep the most recent valid address and note that one exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else if (bus_valid) begin
            prev_q <= addr;
            seen_q <= 1'b1;
        end
    end

    // A change needs a valid cycle and a prior valid address that differs.
    always_comb addr_changed = bus_valid && seen_q && (addr != prev_q);
endmodule

// File: rtl/snoop_sequencer.sv
// Module: arm / count / commit sequencer. A trigger-page access arms it and
// latches the pending byte. It then counts address changes and valid cycles.
// It commits on the TRANS_COUNT-th change if that lands in [WIN_LO, WIN_HI].
// Assumes TRANS_COUNT <= WIN_HI.
module snoop_sequencer
    import snoop_write_pkg::*;
#(
    parameter int TRANS_COUNT = 5,
    parameter int WIN_LO      = 4,
    parameter int WIN_HI      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_changed,
    output logic              commit,
    output logic [DATA_W-1:0] pending
);
    localparam int CW = $clog2(WIN_HI + 2);
    localparam logic [CW-1:0] LAST_T = CW'(TRANS_COUNT - 1);
    localparam logic [CW-1:0] LO_C   = CW'(WIN_LO);
    localparam logic [CW-1:0] HI_C   = CW'(WIN_HI);

    logic          armed_q;
    logic [CW-1:0] tcnt_q;
    logic [CW-1:0] cyc_q;
    logic [CW-1:0] idx;
    logic          is_trig;
    logic          last_t;
    logic          in_win;

    // Decode the trigger page, the current cycle number and the window.
    always_comb begin
        is_trig = bus_valid && addr[ADDR_W-1] && (addr[OFS_W-1:8] == TRIG_HI);
        idx     = cyc_q + 1'b1;
        last_t  = armed_q && addr_changed && (tcnt_q == LAST_T);
        in_win  = (idx >= LO_C) && (idx <= HI_C);
        commit  = last_t && in_win && addr[ADDR_W-1] && !is_trig;
    end

    // Arm on the trigger page, count while armed, disarm at target or window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            pending <= '0;
            tcnt_q  <= '0;
            cyc_q   <= '0;
        end else if (is_trig) begin
            armed_q <= 1'b1;
            pending <= addr[DATA_W-1:0];
            tcnt_q  <= '0;
            cyc_q   <= '0;
        end else if (bus_valid && armed_q) begin
            if (last_t || idx >= HI_C) begin
                armed_q <= 1'b0;
            end else begin
                tcnt_q <= tcnt_q + CW'(addr_changed);
                cyc_q  <= idx;
            end
        end
    end
endmodule

// File: rtl/snoop_bus_drive.sv
// Module: turns a commit into a control load or a RAM write and serves the
// status read. Assumes commit only occurs on a valid cartridge access. The
// status offset always wins the data bus and is never written.
module snoop_bus_drive
    import snoop_write_pkg::*;
#(
    parameter int WE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tape_in,
    input  logic              commit,
    input  logic [DATA_W-1:0] pending,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ram_we,
    output logic [DATA_W-1:0] ctrl_q
);
    logic at_ctrl;
    logic at_stat;
    logic ram_go;

    // Decode this cycle's action from the offset and the write-enable bit.
    always_comb begin
        at_ctrl  = addr[OFS_W-1:0] == CTRL_OFS;
        at_stat  = bus_valid && addr[ADDR_W-1] && (addr[OFS_W-1:0] == STAT_OFS);
        ram_go   = commit && !at_ctrl && !at_stat && ctrl_q[WE_BIT];
        ram_we   = ram_go;
        data_oe  = at_stat || ram_go;
        if (at_stat)     data_out = {{(DATA_W-1){1'b0}}, tape_in};
        else if (ram_go) data_out = pending;
        else             data_out = '0;
    end

    // Load the control register when a commit lands on the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl_q <= '0;
        else if (commit && at_ctrl)  ctrl_q <= pending;
    end
endmodule

// File: rtl/snoop_write_ctl.sv
// Module: top of the read-timed write synthesizer. Wires the address
// tracker, the sequencer and the bus driver. Assumes a synchronous
// active-low reset and one bus_valid pulse per processor bus cycle.
module snoop_write_ctl
    import snoop_write_pkg::*;
#(
    parameter int TRANS_COUNT = 5,
    parameter int WIN_LO      = 4,
    parameter int WIN_HI      = 6,
    parameter int WE_BIT      = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic [12:0] addr,
    input  logic        tape_in,
    output logic [7:0]  data_out,
    output logic        data_oe,
    output logic        ram_we,
    output logic [11:0] ram_addr,
    output logic [7:0]  ctrl_reg
);
    logic              addr_changed;
    logic              commit;
    logic [DATA_W-1:0] pending;

    snoop_addr_track u_track (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
        .addr_changed(addr_changed)
    );

    snoop_sequencer #(
        .TRANS_COUNT(TRANS_COUNT), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
        .addr_changed(addr_changed), .commit(commit), .pending(pending)
    );

    snoop_bus_drive #(.WE_BIT(WE_BIT)) u_drive (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
        .tape_in(tape_in), .commit(commit), .pending(pending),
        .data_out(data_out), .data_oe(data_oe), .ram_we(ram_we),
        .ctrl_q(ctrl_reg)
    );

    // RAM address follows the bus offset directly.
    always_comb ram_addr = addr[OFS_W-1:0];
endmodule

// File: rtl/snoop_write_ctl_chk.sv
// Checker: port-level properties of the read-timed write synthesizer,
// bound to every instance of the top module.
module snoop_write_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic [12:0] addr,
    input logic        tape_in,
    input logic [7:0]  data_out,
    input logic        data_oe,
    input logic        ram_we,
    input logic [7:0]  ctrl_reg
);
    // R2
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && addr == 13'h1FF9) |->
            (data_oe && !ram_we && data_out == {7'b0, tape_in}));

    // R6
    ctrl_load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_reg) |->
            ($past(bus_valid) && $past(addr) == 13'h1FF8));

    // R7
    write_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (data_oe && bus_valid));

    // R8
    write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ctrl_reg[1]);

    // R10
    outside_cart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr[12] |-> !ram_we);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!ram_we && !data_oe));
endmodule

bind snoop_write_ctl snoop_write_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
    .tape_in(tape_in), .data_out(data_out), .data_oe(data_oe),
    .ram_we(ram_we), .ctrl_reg(ctrl_reg)
);

// File: tb/snoop_write_ctl_tb.sv
// Scoreboard bench: the driver applies one bus cycle per clock and queues
// the expected outputs, and the monitor pops and compares them 3 ns after
// the same edge.
module snoop_write_ctl_tb;
    typedef struct {
        logic [7:0]  e_data;
        logic        e_oe;
        logic        e_we;
        logic [11:0] e_raddr;
        logic [7:0]  e_ctrl;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_valid = 0;
    logic [12:0] addr = '0;
    logic        tape_in = 0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        ram_we;
    logic [11:0] ram_addr;
    logic [7:0]  ctrl_reg;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [7:0] cur_ctrl = 8'h00;
    exp_t q[$];

    always #2 clk = ~clk;

    snoop_write_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
        .tape_in(tape_in), .data_out(data_out), .data_oe(data_oe),
        .ram_we(ram_we), .ram_addr(ram_addr), .ctrl_reg(ctrl_reg)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle with explicit expectations.
    task automatic cyc(input logic v, input logic [12:0] a, input logic t,
                       input logic [7:0] ed, input logic eoe, input logic ewe,
                       input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        bus_valid = v; addr = a; tape_in = t;
        e.e_data = ed; e.e_oe = eoe; e.e_we = ewe;
        e.e_raddr = a[11:0]; e.e_ctrl = cur_ctrl; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic quiet(input logic [12:0] a, input string tag);
        cyc(1'b1, a, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic fills(input int n, input logic [12:0] base, input string tag);
        for (int i = 0; i < n; i++) quiet(base + 13'(i), tag);
    endtask

    // Control load: trigger with the byte, four fills, target 0x1FF8.
    task automatic ctrl_load(input logic [7:0] v, input string tag);
        quiet({5'b10000, v}, tag);
        fills(4, 13'h1A00, tag);
        quiet(13'h1FF8, tag);
        cur_ctrl = v;
    endtask

    // Monitor: compare each queued expectation mid-cycle.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(data_oe == e.e_oe, e.tag, "data_oe", 16'(data_oe), 16'(e.e_oe));
                check(ram_we == e.e_we, e.tag, "ram_we", 16'(ram_we), 16'(e.e_we));
                check(data_out == e.e_data, e.tag, "data_out", 16'(data_out), 16'(e.e_data));
                check(ram_addr == e.e_raddr, e.tag, "ram_addr", 16'(ram_addr), 16'(e.e_raddr));
                check(ctrl_reg == e.e_ctrl, e.tag, "ctrl_reg", 16'(ctrl_reg), 16'(e.e_ctrl));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #3;
        check(ctrl_reg == 8'h00 && !data_oe && !ram_we, "R1", "reset outputs",
              {ctrl_reg, 6'b0, data_oe, ram_we}, 16'h0000);
        @(posedge clk); #1; rst_n = 1;

        // R2: status read for both tape levels
        cyc(1, 13'h1FF9, 1'b1, 8'h01, 1, 0, "R2 tape=1");
        cyc(1, 13'h1FF9, 1'b0, 8'h00, 1, 0, "R2 tape=0");

        // R8: RAM target with the enable bit clear writes nothing
        quiet(13'h1055, "R8 arm");
        fills(4, 13'h1A00, "R8 fill");
        quiet(13'h1234, "R8 suppressed write");

        // R6 R3: load control with the enable bit set
        ctrl_load(8'h02, "R6 load");
        quiet(13'h1A10, "R6 visible next cycle");

        // R7 R4: plain write on the 5th transition
        quiet(13'h10A5, "R7 arm");
        fills(4, 13'h1A00, "R7 fill");
        cyc(1, 13'h1345, 0, 8'hA5, 1, 1, "R7 write");
        quiet(13'h1346, "R4 disarmed after target");

        // R4: a repeated address does not count
        quiet(13'h10C3, "R4 arm");
        quiet(13'h1A00, "R4 fill");
        quiet(13'h1A00, "R4 repeat");
        fills(2, 13'h1A01, "R4 fill");
        quiet(13'h1A03, "R4 only 4 transitions");
        cyc(1, 13'h1456, 0, 8'hC3, 1, 1, "R4 write on 5th transition");

        // R5: two repeats push the 5th transition past cycle 6
        quiet(13'h10D7, "R5 arm");
        quiet(13'h1A00, "R5 fill");
        quiet(13'h1A00, "R5 repeat");
        quiet(13'h1A00, "R5 repeat");
        fills(3, 13'h1A01, "R5 fill");
        quiet(13'h1567, "R5 late target not written");

        // R9: re-arming restarts the count
        quiet(13'h1011, "R9 arm1");
        fills(2, 13'h1A00, "R9 fill");
        quiet(13'h1022, "R9 arm2");
        quiet(13'h1A05, "R9 fill");
        quiet(13'h1A06, "R9 old 5th transition not written");
        fills(2, 13'h1A07, "R9 fill");
        cyc(1, 13'h1678, 0, 8'h22, 1, 1, "R9 write new byte");

        // R10: target outside the cartridge, then no leftover write
        quiet(13'h1033, "R10 arm");
        fills(4, 13'h1A00, "R10 fill");
        quiet(13'h0123, "R10 target outside");
        quiet(13'h1789, "R10 disarmed");

        // R10: a page-0 address with bit 12 low does not arm
        quiet(13'h0005, "R10 no arm");
        fills(4, 13'h1A00, "R10 fill");
        quiet(13'h1456, "R10 no write");

        // R2: status offset as target is read, not written
        quiet(13'h1077, "R2 arm");
        fills(4, 13'h1A00, "R2 fill");
        cyc(1, 13'h1FF9, 1'b1, 8'h01, 1, 0, "R2 status target");
        quiet(13'h1345, "R2 disarmed");

        // R11: an idle cycle neither counts nor drives
        quiet(13'h1044, "R11 arm");
        fills(2, 13'h1A00, "R11 fill");
        cyc(0, 13'h1FF9, 1'b1, 8'h00, 0, 0, "R11 idle");
        quiet(13'h1A02, "R11 fill");
        quiet(13'h1A03, "R11 idle not counted");
        cyc(1, 13'h1890, 0, 8'h44, 1, 1, "R11 write");

        // R8: clearing the enable bit stops writes, control loads continue
        ctrl_load(8'h00, "R8 clear enable");
        quiet(13'h1066, "R8 arm");
        fills(4, 13'h1A00, "R8 fill");
        quiet(13'h1999, "R8 write suppressed");
        ctrl_load(8'h06, "R8 load while disabled");
        quiet(13'h1A20, "R8 ctrl updated");

        repeat (3) @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule